// File: doc/BRIEF.md
# Cache Control and Invalidate Sequencer

This block holds the control word of one cache array and turns it into the qualifiers the array needs. The control word has three bits that software can write: an enable bit, a lock bit and an invalidate-all bit. From these bits and the tag-compare results the block decides four things. It decides whether a processor access looks up the cache, whether it is a hit, a miss that allocates, or an access treated as cache-inhibited, and whether a bus snoop reports a hit.

Writing the invalidate-all bit starts a walk over a valid-bit array. The walk clears one line index per clock, from the lowest index to the highest, and no modified data is written back. While the walk runs, processor requests are held with a stall and every snoop reports a miss. The data array, tag compare, replacement choice and bus protocol sit outside this block. The block receives tag-match results as inputs.

Top module: `cache_ctl_seq`

## Requirements
- R1: After reset the control word reads as all zeros, the walk is idle (busy and clear-enable low), and the cache behaves as disabled.
- R2: The control word has the enable bit at position 0, the lock bit at position 1 and the invalidate-all bit at position 2. A read returns enable and lock as last written, and every bit above position 2 reads as 0.
- R3: With enable at 0, a processor request raises only the inhibit output: no lookup, hit, miss, allocate or stall. A snoop reports a miss even when its tag matches.
- R4: With enable at 1 and lock at 0, a request with a tag match gives lookup and hit. A request without a match gives lookup, miss and allocate.
- R5: With enable and lock both at 1, a tag match still gives a hit. A mismatch gives miss and inhibit but no allocate. Snoops still report hits on a tag match.
- R6: A write with the invalidate-all bit at 1 makes that bit read as 1 in the cycle after the write only. It reads as 0 from then on.
- R7: If enable is 1 in that cycle, then from the next cycle busy and clear-enable stay high for exactly NUM_LINES cycles. The clear index runs 0, 1, …, NUM_LINES-1, one step per cycle.
- R8: If enable is 0 in that cycle, no walk starts and clear-enable stays low.
- R9: A processor request during the walk gets a stall and no lookup. Once the walk ends, the same held request is looked up normally.
- R10: During the walk every snoop reports a miss. After the walk, tag-matching snoops report hits again.
- R11: An invalidate-all write that arrives while a walk is running neither restarts nor lengthens the walk. Its enable and lock bits still take effect, and the invalidate-all bit does not read as 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wr_data | input | CTRL_W | Control word write value |
| cfg_rd_data | output | CTRL_W | Control word read value |
| cpu_req | input | 1 | Processor access request |
| cpu_tag_match | input | 1 | Tag compare result for the processor access |
| cpu_stall | output | 1 | Request held while the walk runs |
| cpu_lookup | output | 1 | Access is looked up in the cache |
| cpu_hit | output | 1 | Access hits |
| cpu_miss | output | 1 | Access misses a looked-up cache |
| cpu_alloc | output | 1 | Miss allocates a line |
| cpu_inhibit | output | 1 | Access is treated as cache-inhibited |
| snp_req | input | 1 | Bus snoop request |
| snp_tag_match | input | 1 | Tag compare result for the snoop |
| snp_hit | output | 1 | Snoop response: 1 hit, 0 miss |
| walk_busy | output | 1 | Invalidate walk in progress |
| vclr_en | output | 1 | Clear strobe toward the valid-bit array |
| vclr_idx | output | IDX_W | Line index being cleared |

## Verification
The hardest situation to reach from the ports is a second invalidate-all write that arrives partway through a running walk. The walk must neither restart nor stretch, and the enable and lock bits of that same write must still land. The bench starts a walk and counts clear cycles at the ports. At the fourth clear index it issues a write carrying all three bits. It then checks that the index keeps climbing without a reset to 0 and that busy falls after exactly NUM_LINES cycles. Finally it reads back a control word with lock set and the invalidate-all bit clear.

// File: rtl/cache_ctl_pkg.sv
package cache_ctl_pkg;
   // Bit positions inside the control word; software depends on them.
   localparam int unsigned CW_EN_POS   = 0;
   localparam int unsigned CW_LOCK_POS = 1;
   localparam int unsigned CW_INV_POS  = 2;
   localparam int unsigned CW_MIN_W    = 3;

   typedef struct packed {
      logic inv_pend;
      logic lock;
      logic en;
   } ctl_state_t;

   typedef enum logic [1:0] {
      ACC_IDLE    = 2'd0,
      ACC_STALL   = 2'd1,
      ACC_BYPASS  = 2'd2,
      ACC_CACHED  = 2'd3
   } acc_kind_t;
endpackage

// File: rtl/cache_ctl_word.sv
module cache_ctl_word
   import cache_ctl_pkg::*;
#(
   parameter int unsigned CTRL_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   input  logic              walk_busy,
   output ctl_state_t        state,
   output logic              walk_start,
   output logic [CTRL_W-1:0] rd_data
);
   ctl_state_t state_q;
   logic       inv_req;

   // A new request is taken only when neither a walk nor a pending start exists.
   assign inv_req = wr_en && wr_data[CW_INV_POS] && !walk_busy && !state_q.inv_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= '0;
      end else begin
         if (wr_en) begin
            state_q.en   <= wr_data[CW_EN_POS];
            state_q.lock <= wr_data[CW_LOCK_POS];
         end
         // Pending flag lives exactly one cycle: it self-clears as the walk begins.
         state_q.inv_pend <= inv_req;
      end
   end

   assign state      = state_q;
   assign walk_start = state_q.inv_pend && state_q.en;

   always_comb begin
      rd_data              = '0;
      rd_data[CW_EN_POS]   = state_q.en;
      rd_data[CW_LOCK_POS] = state_q.lock;
      rd_data[CW_INV_POS]  = state_q.inv_pend;
   end

   generate
      if (CTRL_W > CW_MIN_W) begin : g_spare
         logic unused_spare_bits;
         assign unused_spare_bits = ^wr_data[CTRL_W-1:CW_MIN_W];
      end
   endgenerate

   // R6
   inv_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[CW_INV_POS] && !walk_busy && !state_q.inv_pend) |=> state_q.inv_pend);
   // R6
   inv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state_q.inv_pend |=> !state_q.inv_pend);
   // R11
   inv_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      walk_busy |=> !state_q.inv_pend);
endmodule

// File: rtl/cache_inv_walker.sv
module cache_inv_walker #(
   parameter int unsigned NUM_LINES = 64,
   localparam int unsigned IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             busy,
   output logic             clr_en,
   output logic [IDX_W-1:0] clr_idx
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

   logic             busy_q;
   logic [IDX_W-1:0] idx_q;
   logic             at_last;

   assign at_last = (idx_q == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
      end else if (!busy_q) begin
         if (start) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
         end
      end else if (at_last) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
      end else begin
         idx_q <= idx_q + IDX_W'(1);
      end
   end

   assign busy    = busy_q;
   assign clr_en  = busy_q;
   assign clr_idx = idx_q;

   // R7
   walk_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy_q) |=> (busy_q && idx_q == '0));
   // R7
   walk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !at_last) |=> (busy_q && idx_q == $past(idx_q) + IDX_W'(1)));
   // R7
   walk_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && at_last) |=> !busy_q);
endmodule

// File: rtl/cache_access_qual.sv
module cache_access_qual
   import cache_ctl_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  ctl_state_t state,
   input  logic       walk_busy,
   input  logic       cpu_req,
   input  logic       cpu_tag_match,
   input  logic       snp_req,
   input  logic       snp_tag_match,
   output logic       cpu_stall,
   output logic       cpu_lookup,
   output logic       cpu_hit,
   output logic       cpu_miss,
   output logic       cpu_alloc,
   output logic       cpu_inhibit,
   output logic       snp_hit
);
   acc_kind_t kind;

   always_comb begin
      if (!cpu_req)        kind = ACC_IDLE;
      else if (walk_busy)  kind = ACC_STALL;
      else if (!state.en)  kind = ACC_BYPASS;
      else                 kind = ACC_CACHED;
   end

   always_comb begin
      cpu_stall   = 1'b0;
      cpu_lookup  = 1'b0;
      cpu_hit     = 1'b0;
      cpu_miss    = 1'b0;
      cpu_alloc   = 1'b0;
      cpu_inhibit = 1'b0;
      unique case (kind)
         ACC_STALL:  cpu_stall   = 1'b1;
         ACC_BYPASS: cpu_inhibit = 1'b1;
         ACC_CACHED: begin
            cpu_lookup = 1'b1;
            if (cpu_tag_match) begin
               cpu_hit = 1'b1;
            end else begin
               cpu_miss    = 1'b1;
               cpu_alloc   = !state.lock;
               cpu_inhibit = state.lock;
            end
         end
         default: ;
      endcase
   end

   assign snp_hit = snp_req && snp_tag_match && state.en && !walk_busy;

   // R3
   disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !state.en |-> (!cpu_lookup && !snp_hit));
   // R5
   lock_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state.lock |-> !cpu_alloc);
   // R9
   stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_busy && cpu_req) |-> (cpu_stall && !cpu_lookup));
   // R10
   snoop_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      walk_busy |-> !snp_hit);
endmodule

// File: rtl/cache_ctl_seq.sv
module cache_ctl_seq
   import cache_ctl_pkg::*;
#(
   parameter int unsigned NUM_LINES = 64,
   parameter int unsigned CTRL_W    = 8,
   localparam int unsigned IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [CTRL_W-1:0] cfg_wr_data,
   output logic [CTRL_W-1:0] cfg_rd_data,
   input  logic              cpu_req,
   input  logic              cpu_tag_match,
   output logic              cpu_stall,
   output logic              cpu_lookup,
   output logic              cpu_hit,
   output logic              cpu_miss,
   output logic              cpu_alloc,
   output logic              cpu_inhibit,
   input  logic              snp_req,
   input  logic              snp_tag_match,
   output logic              snp_hit,
   output logic              walk_busy,
   output logic              vclr_en,
   output logic [IDX_W-1:0]  vclr_idx
);
   generate
      if (NUM_LINES < 2) begin : g_bad_lines
         $error("cache_ctl_seq: NUM_LINES must be at least 2");
      end
      if (CTRL_W < CW_MIN_W) begin : g_bad_width
         $error("cache_ctl_seq: CTRL_W too narrow for the control fields");
      end
   endgenerate

   ctl_state_t state;
   logic       walk_start;
   logic       busy;

   cache_ctl_word #(.CTRL_W(CTRL_W)) u_word (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (cfg_wr_en),
      .wr_data    (cfg_wr_data),
      .walk_busy  (busy),
      .state      (state),
      .walk_start (walk_start),
      .rd_data    (cfg_rd_data)
   );

   cache_inv_walker #(.NUM_LINES(NUM_LINES)) u_walk (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (walk_start),
      .busy    (busy),
      .clr_en  (vclr_en),
      .clr_idx (vclr_idx)
   );

   cache_access_qual u_qual (
      .clk           (clk),
      .rst_n         (rst_n),
      .state         (state),
      .walk_busy     (busy),
      .cpu_req       (cpu_req),
      .cpu_tag_match (cpu_tag_match),
      .snp_req       (snp_req),
      .snp_tag_match (snp_tag_match),
      .cpu_stall     (cpu_stall),
      .cpu_lookup    (cpu_lookup),
      .cpu_hit       (cpu_hit),
      .cpu_miss      (cpu_miss),
      .cpu_alloc     (cpu_alloc),
      .cpu_inhibit   (cpu_inhibit),
      .snp_hit       (snp_hit)
   );

   assign walk_busy = busy;

   // R8
   no_walk_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state.inv_pend && !state.en && !busy) |=> !vclr_en);
endmodule

// File: tb/cache_ctl_seq_bench.sv
module cache_ctl_seq_bench;
   localparam int unsigned N  = 16;
   localparam int unsigned CW = 8;
   localparam int unsigned IW = $clog2(N);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr_en = 1'b0;
   logic [CW-1:0] cfg_wr_data = '0;
   logic [CW-1:0] cfg_rd_data;
   logic          cpu_req = 1'b0, cpu_tag_match = 1'b0;
   logic          cpu_stall, cpu_lookup, cpu_hit, cpu_miss, cpu_alloc, cpu_inhibit;
   logic          snp_req = 1'b0, snp_tag_match = 1'b0;
   logic          snp_hit, walk_busy, vclr_en;
   logic [IW-1:0] vclr_idx;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;   // 50 MHz

   cache_ctl_seq #(.NUM_LINES(N), .CTRL_W(CW)) u_cache_ctl_seq (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
      .cpu_req(cpu_req), .cpu_tag_match(cpu_tag_match),
      .cpu_stall(cpu_stall), .cpu_lookup(cpu_lookup), .cpu_hit(cpu_hit),
      .cpu_miss(cpu_miss), .cpu_alloc(cpu_alloc), .cpu_inhibit(cpu_inhibit),
      .snp_req(snp_req), .snp_tag_match(snp_tag_match), .snp_hit(snp_hit),
      .walk_busy(walk_busy), .vclr_en(vclr_en), .vclr_idx(vclr_idx)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // outputs packed {stall,lookup,hit,miss,alloc,inhibit}
   function automatic int cpu_vec();
      return {cpu_stall, cpu_lookup, cpu_hit, cpu_miss, cpu_alloc, cpu_inhibit};
   endfunction

   task automatic cfg_write(input logic [CW-1:0] d);
      @(negedge clk);
      cfg_wr_en = 1'b1;
      cfg_wr_data = d;
      @(negedge clk);
      cfg_wr_en = 1'b0;
      cfg_wr_data = '0;
      #1;
   endtask

   task automatic cpu_probe(input bit tag, input int exp, input string req);
      @(negedge clk);
      cpu_req = 1'b1;
      cpu_tag_match = tag;
      #1;
      chk(cpu_vec() == exp, req, cpu_vec(), exp);
      cpu_req = 1'b0;
   endtask

   task automatic t_reset();
      #1;
      chk(cfg_rd_data == '0, "R1", cfg_rd_data, 0);
      chk(!walk_busy && !vclr_en, "R1", {walk_busy, vclr_en}, 0);
      cpu_probe(1'b1, 6'b000001, "R1");
   endtask

   task automatic t_regs();
      cfg_write(8'hFB);   // upper bits set, inv clear, lock and en set
      chk(cfg_rd_data == 8'h03, "R2", cfg_rd_data, 8'h03);
      cfg_write(8'h02);
      chk(cfg_rd_data == 8'h02, "R2", cfg_rd_data, 8'h02);
   endtask

   task automatic t_disabled();
      cfg_write(8'h00);
      cpu_probe(1'b1, 6'b000001, "R3");
      cpu_probe(1'b0, 6'b000001, "R3");
      @(negedge clk);
      snp_req = 1'b1; snp_tag_match = 1'b1; #1;
      chk(snp_hit == 1'b0, "R3", snp_hit, 0);
      snp_req = 1'b0; snp_tag_match = 1'b0;
   endtask

   task automatic t_normal();
      cfg_write(8'h01);
      cpu_probe(1'b1, 6'b011000, "R4");
      cpu_probe(1'b0, 6'b010110, "R4");
   endtask

   task automatic t_lock();
      cfg_write(8'h03);
      cpu_probe(1'b1, 6'b011000, "R5");
      cpu_probe(1'b0, 6'b010101, "R5");
      @(negedge clk);
      snp_req = 1'b1; snp_tag_match = 1'b1; #1;
      chk(snp_hit == 1'b1, "R5", snp_hit, 1);
      snp_req = 1'b0; snp_tag_match = 1'b0;
   endtask

   task automatic t_walk();
      cfg_write(8'h05);
      chk(cfg_rd_data == 8'h05, "R6", cfg_rd_data, 8'h05);
      chk(!vclr_en, "R7", vclr_en, 0);
      for (int k = 0; k < N; k++) begin
         @(negedge clk); #1;
         chk(walk_busy && vclr_en && vclr_idx == IW'(k), "R7", {walk_busy, vclr_en, vclr_idx}, {2'b11, IW'(k)});
         if (k == 0) chk(cfg_rd_data == 8'h01, "R6", cfg_rd_data, 8'h01);
      end
      @(negedge clk); #1;
      chk(!walk_busy && !vclr_en, "R7", {walk_busy, vclr_en}, 0);
      chk(cfg_rd_data == 8'h01, "R6", cfg_rd_data, 8'h01);
   endtask

   task automatic t_walk_off();
      cfg_write(8'h04);
      chk(cfg_rd_data == 8'h04, "R8", cfg_rd_data, 8'h04);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk); #1;
         chk(!vclr_en && !walk_busy, "R8", {walk_busy, vclr_en}, 0);
      end
      chk(cfg_rd_data == 8'h00, "R8", cfg_rd_data, 0);
   endtask

   task automatic t_stall_snoop();
      cfg_write(8'h05);
      cpu_req = 1'b1; cpu_tag_match = 1'b1;
      snp_req = 1'b1; snp_tag_match = 1'b1;
      for (int k = 0; k < N; k++) begin
         @(negedge clk); #1;
         chk(cpu_vec() == 6'b100000, "R9", cpu_vec(), 6'b100000);
         chk(snp_hit == 1'b0, "R10", snp_hit, 0);
      end
      @(negedge clk); #1;
      chk(cpu_vec() == 6'b011000, "R9", cpu_vec(), 6'b011000);
      chk(snp_hit == 1'b1, "R10", snp_hit, 1);
      cpu_req = 1'b0; cpu_tag_match = 1'b0;
      snp_req = 1'b0; snp_tag_match = 1'b0;
   endtask

   task automatic t_rewrite();
      int busy_cycles;
      cfg_write(8'h05);
      busy_cycles = 0;
      for (int k = 0; k < N + 4; k++) begin
         @(negedge clk);
         cfg_wr_en = (k == 4);
         cfg_wr_data = (k == 4) ? 8'h07 : 8'h00;
         #1;
         if (walk_busy) begin
            busy_cycles++;
            if (k < N) chk(vclr_idx == IW'(k), "R11", vclr_idx, k);
         end
      end
      cfg_wr_en = 1'b0;
      chk(busy_cycles == N, "R11", busy_cycles, N);
      chk(cfg_rd_data == 8'h03, "R11", cfg_rd_data, 8'h03);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_disabled();
      t_normal();
      t_lock();
      t_walk();
      t_walk_off();
      t_stall_snoop();
      t_rewrite();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule